// File: doc/BRIEF.md
# Pseudo-Cause Interrupt Aggregator

This block folds the interrupt outputs of three cause-register groups into one summary register and drives one host interrupt line from it. The groups are receive, transmit and miscellaneous. Each group's input is already the OR of that group's unmasked pending bits. Every summary bit is sticky: it latches when its group asserts and holds until the host reads the summary. The read itself clears the register, so the host writes no acknowledge.

A separate software mask register decides which summary bits reach the interrupt line. A mask bit of one blocks its bit. The mask comes out of reset as all ones, so the line starts silent. The host enables the three sources by writing a mask that has zeros at bit positions 0, 1 and 2.

The host reaches both registers through a small request/response port. A request moves on a cycle where `req_valid_i` and `req_ready_o` are both high. Every accepted read produces one response word. That word stays valid and unchanged until `rsp_ready_i` takes it. While a response is waiting and `rsp_ready_i` is low, `req_ready_o` is low, which pushes back on the next request. Writes produce no response.

Top module: `pca_aggregator`

## Requirements
- R1: After reset `irq_o` is low, the mask register (address 4) reads 32'hFFFF_FFFF and the summary register (address 0) reads 0.
- R2: A group input high for one cycle sets its summary bit: receive at bit 0, transmit at bit 1, miscellaneous at bit 2. The bit stays set after the input drops, until a summary read, whatever the mask holds.
- R3: An accepted read of address 0 returns the summary value held before that read and clears the register. Bits 31..3 of the result are always zero, so a low byte of 8'hFF never appears.
- R4: If a group input is high in the cycle a summary read is accepted, its bit is set again in the cycle after the read. A second read then returns it again.
- R5: `irq_o` is the OR over the three bits of (summary AND NOT mask bit). A mask of all ones keeps `irq_o` low whatever is pending.
- R6: A write to address 4 stores the full 32-bit word, and reading address 4 returns it. With 32'hFFFF_FFF8 written, any pending summary bit raises `irq_o`.
- R7: `req_ready_o` equals NOT `rsp_valid_o` OR `rsp_ready_i`. A response stays valid with the same data until it is taken.
- R8: Writes to address 0 or to an unmapped address change neither register. Reads of an unmapped address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| grp_irq_i | input | 3 | Group interrupts: [0] receive, [1] transmit, [2] miscellaneous |
| req_valid_i | input | 1 | Register request valid |
| req_ready_o | output | 1 | Register request ready |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 4 | Register address: 0 summary, 4 mask |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read response valid |
| rsp_ready_i | input | 1 | Read response taken |
| rsp_data_o | output | 32 | Read response data |
| irq_o | output | 1 | Host interrupt line |

## Verification
A summary bit that is lost or stuck shows up at the interrupt line in the very cycle after it goes wrong, once its mask bit is open. It also shows up in the next summary read. A clear that fails to fire, or fires too early, shows up in back-to-back reads: with the group input held high, the second read must repeat the bit, and with the input low it must return zero. A wrong mask state shows as an interrupt line that is silent, or raised, when it should not be. A broken response buffer shows within one cycle of a stalled `rsp_ready_i`, as data that changes or a request that is accepted.

// File: rtl/pca_pkg.sv
package pca_pkg;
  localparam int NUM_GRP  = 3;
  localparam int RX_BIT   = 0;
  localparam int TX_BIT   = 1;
  localparam int MISC_BIT = 2;
endpackage

// File: rtl/pca_cause_collect.sv
module pca_cause_collect #(
  parameter int NGRP = pca_pkg::NUM_GRP
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NGRP-1:0] grp_i,
  input  logic            clr_i,
  output logic [NGRP-1:0] cause_o
);
  // one sticky bit per group; a clearing read still lets a live source in
  for (genvar g = 0; g < NGRP; g++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    bit_q <= 1'b0;
      else if (clr_i) bit_q <= grp_i[g];
      else            bit_q <= bit_q | grp_i[g];
    end
    assign cause_o[g] = bit_q;
  end
endmodule

// File: rtl/pca_swmask.sv
module pca_swmask #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_o <= '1;
    else if (we_i) mask_o <= wdata_i;
  end
endmodule

// File: rtl/pca_rsp_slot.sv
module pca_rsp_slot #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              rsp_ready_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              free_o
);
  assign free_o = !rsp_valid_o || rsp_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else if (load_i) begin
      rsp_valid_o <= 1'b1;
      rsp_data_o  <= data_i;
    end else if (rsp_ready_i) begin
      rsp_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pca_aggregator.sv
module pca_aggregator #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 4,
  parameter int CAUSE_ADDR = 0,
  parameter int MASK_ADDR  = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [pca_pkg::NUM_GRP-1:0] grp_irq_i,
  input  logic                        req_valid_i,
  output logic                        req_ready_o,
  input  logic                        req_write_i,
  input  logic [ADDR_W-1:0]           req_addr_i,
  input  logic [DATA_W-1:0]           req_wdata_i,
  output logic                        rsp_valid_o,
  input  logic                        rsp_ready_i,
  output logic [DATA_W-1:0]           rsp_data_o,
  output logic                        irq_o
);
  localparam int NGRP = pca_pkg::NUM_GRP;
  localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(CAUSE_ADDR);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(MASK_ADDR);

  logic              acc, rd_cause, wr_mask, rd_any;
  logic [NGRP-1:0]   cause_q;
  logic [DATA_W-1:0] mask_q, rd_data;

  assign acc      = req_valid_i && req_ready_o;
  assign rd_any   = acc && !req_write_i;
  assign rd_cause = rd_any && (req_addr_i == A_CAUSE);
  assign wr_mask  = acc && req_write_i && (req_addr_i == A_MASK);

  always_comb begin
    rd_data = '0;
    if (req_addr_i == A_CAUSE)     rd_data = DATA_W'(cause_q);
    else if (req_addr_i == A_MASK) rd_data = mask_q;
  end

  pca_cause_collect #(.NGRP(NGRP)) u_cause (
    .clk_i(clk_i), .rst_ni(rst_ni), .grp_i(grp_irq_i),
    .clr_i(rd_cause), .cause_o(cause_q));

  pca_swmask #(.DATA_W(DATA_W)) u_mask (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_mask),
    .wdata_i(req_wdata_i), .mask_o(mask_q));

  pca_rsp_slot #(.DATA_W(DATA_W)) u_rsp (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(rd_any), .data_i(rd_data),
    .rsp_ready_i(rsp_ready_i), .rsp_valid_o(rsp_valid_o),
    .rsp_data_o(rsp_data_o), .free_o(req_ready_o));

  assign irq_o = |(cause_q & ~mask_q[NGRP-1:0]);
endmodule

// File: rtl/pca_aggregator_chk.sv
module pca_aggregator_chk #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 4,
  parameter int CAUSE_ADDR = 0,
  parameter int NGRP       = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NGRP-1:0]   grp_irq_i,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              req_write_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              rsp_valid_o,
  input logic              rsp_ready_i,
  input logic [DATA_W-1:0] rsp_data_o,
  input logic              irq_o,
  input logic [NGRP-1:0]   cause_q,
  input logic [DATA_W-1:0] mask_q
);
  logic cause_rd;
  assign cause_rd = req_valid_i && req_ready_o && !req_write_i
                    && (req_addr_i == ADDR_W'(CAUSE_ADDR));

  a_r5_all_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_q) |-> !irq_o);
  a_r7_rsp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_data_o)));
  a_r7_backpressure: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |-> !req_ready_o);
  a_r4_reassert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_rd |=> (cause_q == $past(grp_irq_i)));
  a_r2_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cause_rd |=> ((cause_q & $past(cause_q)) == $past(cause_q)));
  a_r3_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_rd |=> ((rsp_data_o >> NGRP) == '0));
endmodule

bind pca_aggregator pca_aggregator_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CAUSE_ADDR(CAUSE_ADDR), .NGRP(NGRP)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .grp_irq_i(grp_irq_i),
  .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .req_write_i(req_write_i), .req_addr_i(req_addr_i),
  .rsp_valid_o(rsp_valid_o), .rsp_ready_i(rsp_ready_i),
  .rsp_data_o(rsp_data_o), .irq_o(irq_o),
  .cause_q(cause_q), .mask_q(mask_q));

// File: tb/pca_aggregator_tb.sv
module pca_aggregator_tb_top;
  logic        clk = 0, rst_n = 0;
  logic [2:0]  grp = '0;
  logic        req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [3:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, irq;
  logic [31:0] rsp_data;

  int checks = 0, errors = 0, cycles = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  pca_aggregator dut_i (
    .clk_i(clk), .rst_ni(rst_n), .grp_irq_i(grp),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_data_o(rsp_data),
    .irq_o(irq));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: one request; reads push their expected word into the scoreboard
  task automatic issue(bit wr, logic [3:0] a, logic [31:0] d, string tag);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    if (!wr) begin exp_q.push_back(d); tag_q.push_back(tag); end
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(logic [2:0] v);
    @(negedge clk); grp = v;
    @(negedge clk); grp = '0;
  endtask

  // monitor: compares every response as it is taken
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) check("R7 unexpected response", rsp_data, 32'hx);
        else check(tag_q.pop_front(), rsp_data, exp_q.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3); rst_n = 1; idle(1);
    // R1 reset state
    check("R1 irq low", {31'b0, irq}, 0);
    issue(0, 4, 32'hFFFF_FFFF, "R1 mask reset");
    issue(0, 0, 0, "R1 cause reset");
    // R2/R5 masked source latches, line stays low
    pulse(3'b001); idle(2);
    check("R5 all-ones mask blocks", {31'b0, irq}, 0);
    issue(0, 0, 1, "R2 rx bit sticky");
    issue(0, 0, 0, "R3 cleared by read");
    // R6 enable all three
    issue(1, 4, 32'hFFFF_FFF8, "");
    issue(0, 4, 32'hFFFF_FFF8, "R6 mask readback");
    pulse(3'b010); idle(1);
    check("R6 tx raises irq", {31'b0, irq}, 1);
    issue(0, 0, 2, "R2 tx bit");
    idle(1);
    check("R3 irq drops after read", {31'b0, irq}, 0);
    // R4 held source reasserts
    @(negedge clk); grp = 3'b100;
    idle(1);
    issue(0, 0, 4, "R4 first read");
    issue(0, 0, 4, "R4 reasserted");
    check("R4 irq held", {31'b0, irq}, 1);
    grp = '0;
    issue(0, 0, 4, "R4 last set before drop");
    issue(0, 0, 0, "R3 clear after drop");
    // R5 partial mask, summary independent of mask
    issue(1, 4, 32'hFFFF_FFFD, "");
    pulse(3'b101); idle(1);
    check("R5 masked bits keep irq low", {31'b0, irq}, 0);
    issue(0, 0, 5, "R2 rx+misc summary");
    // R8 ignored writes
    pulse(3'b001);
    issue(1, 0, 32'h0, "");
    issue(0, 0, 1, "R8 cause write ignored");
    issue(1, 8, 32'h0, "");
    issue(0, 4, 32'hFFFF_FFFD, "R8 unmapped write ignored");
    issue(0, 8, 0, "R8 unmapped read zero");
    // R7 back-pressure
    @(negedge clk); rsp_ready = 0;
    issue(0, 4, 32'hFFFF_FFFD, "R7 stalled response");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      check("R7 ready low while stalled", {31'b0, req_ready}, 0);
      check("R7 data held", rsp_data, 32'hFFFF_FFFD);
    end
    rsp_ready = 1;
    idle(3);
    check("R7 scoreboard drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule